// File: doc/BRIEF.md
# SPI Serial Memory Command Front End

This block is the slave side of a serial peripheral interface in front of a byte-addressable nonvolatile memory. It oversamples the serial clock, chip select, data-in and pause (hold) pins with the system clock. It collects a one-byte command, decodes it, and steers the rest of the selection. Status reads stream the status byte supplied by the status logic. Status writes hand over one byte. Memory reads take a 16-bit address and stream bytes from a synchronous RAM model with an address counter that increments and wraps. Memory writes pass each received byte, with its page-wrapped address, to the page write buffer.

The data-out pin is modelled as a value plus an output enable, so the pad ring can build the tri-state driver. Write-enable tracking, protection checks and the nonvolatile commit are done by neighbouring blocks. This block produces command pulses and marks a correctly framed end of selection.

Top module: `spi_mem_front`

## Requirements
- R1: Data-out is not driven while chip select (active low) is high. After reset, no command is accepted until chip select has been seen high and then low again.
- R2: Input bits are taken MSB first on rising serial clock edges, and output bits change only after falling edges. Both clock idle levels (low, mode 0, and high, mode 3) work.
- R3: Opcode 0x06 gives one pulse on `wel_set_o` and opcode 0x04 gives one pulse on `wel_clr_o`. Afterwards, further bits in the same selection have no effect until chip select rises.
- R4: Opcode 0x05 drives `status_i` on data-out, MSB first, repeated byte after byte for as long as the clock runs.
- R5: Opcode 0x03 takes a 16-bit address, of which only the low ADDR_W bits are used. It then streams the RAM from that address, incrementing after each byte and wrapping from the top address to 0.
- R6: Opcode 0x03 received while `wip_i` is high is rejected: data-out stays undriven and the rest of the selection is ignored.
- R7: Opcode 0x02 takes a 16-bit address. Each following complete byte gives a `pg_byte_valid_o` pulse with that byte and its address; only the low PAGE_W address bits advance, wrapping within the page.
- R8: `pg_commit_o` pulses on chip select rising only when a 0x02 selection carried one or more whole data bytes and no extra bits. `sr_commit_o` pulses only when a 0x01 selection carried exactly one byte after the opcode, which is also shown as one `sr_byte_valid_o` pulse.
- R9: Any other opcode makes the block ignore the rest of the selection.
- R10: A pause starts when hold is low, the serial clock is low and the device is selected. During the pause, data-out is undriven and clock and data edges are ignored. When hold returns high, the transfer continues where it stopped.
- R11: Chip select rising during a pause aborts the transfer. A new command is accepted only after hold is high and chip select has been taken high and then low again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sck_i | input | 1 | Serial clock pin |
| spi_csn_i | input | 1 | Chip select pin, active low |
| spi_mosi_i | input | 1 | Serial data into the device |
| spi_holdn_i | input | 1 | Pause request pin, active low |
| spi_miso_o | output | 1 | Serial data out value |
| spi_miso_oe_o | output | 1 | Output enable for the data-out pad |
| wip_i | input | 1 | Internal write cycle running |
| status_i | input | 8 | Status byte to send on status read |
| wel_set_o | output | 1 | Write-enable set command pulse |
| wel_clr_o | output | 1 | Write-enable clear command pulse |
| sr_byte_o | output | 8 | Status byte received by status write |
| sr_byte_valid_o | output | 1 | Pulse: `sr_byte_o` is valid |
| sr_commit_o | output | 1 | Pulse: status write framed correctly at deselect |
| pg_byte_o | output | 8 | Data byte for the page buffer |
| pg_addr_o | output | ADDR_W | Array address of `pg_byte_o` |
| pg_byte_valid_o | output | 1 | Pulse: page byte and address valid |
| pg_commit_o | output | 1 | Pulse: memory write framed correctly at deselect |
| mem_we_i | input | 1 | RAM model write enable (from the commit block) |
| mem_waddr_i | input | ADDR_W | RAM model write address |
| mem_wdata_i | input | 8 | RAM model write data |

## Verification
A wrong bit counter or a wrong decode state shows within one byte time as a missing or extra command pulse, or as a data-out stream shifted by one or more bit positions. A wrong address counter shows at the next byte boundary of a read, as the wrong RAM byte, or after the top address as a stream that does not wrap to 0. Pause and reject faults show at once on the output enable, and after the pause as a corrupted continuation byte or a command accepted when it should not be. Framing faults show only at deselect, as a commit pulse that is present or absent against the count of bits sent.

// File: rtl/spi_fe_pkg.sv
// Shared command codes and sequencer states for the serial memory front end.
// Assumes: opcodes are one byte, sent MSB first.
package spi_fe_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,     // deselected, counters cleared
        ST_WAIT,     // ignore everything until chip select rises
        ST_OPC,      // collecting the command byte
        ST_ADDR,     // collecting two address bytes
        ST_RD,       // streaming array bytes out
        ST_WR,       // passing data bytes to the page buffer
        ST_SR_OUT,   // streaming the status byte out
        ST_SR_IN,    // collecting the new status byte
        ST_SR_DONE   // status byte complete, waiting for deselect
    } fe_state_e;

    localparam logic [7:0] OP_WEN  = 8'h06;
    localparam logic [7:0] OP_WDIS = 8'h04;
    localparam logic [7:0] OP_SRD  = 8'h05;
    localparam logic [7:0] OP_SWR  = 8'h01;
    localparam logic [7:0] OP_MRD  = 8'h03;
    localparam logic [7:0] OP_MWR  = 8'h02;

endpackage

// File: rtl/spi_fe_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous pins.
// Assumes: each bit is independent, and the pins are slow compared with clk.
// All stages reset to 0, so a pin held low through reset is not seen as an edge.
module spi_fe_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stg [STAGES];

    // First stage captures the raw pins.
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= d_i;
    end

    generate
        for (genvar i = 1; i < STAGES; i++) begin : g_stage
            // Each further stage re-registers the previous one.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[i] <= '0;
                else        stg[i] <= stg[i-1];
            end
        end
    endgenerate

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/spi_fe_pace.sv
// Serial clock edge detector and pause (hold) tracker.
// Assumes: all inputs are already synchronized to clk.
// Edges are suppressed while a pause is active.
module spi_fe_pace (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_s,
    input  logic csn_s,
    input  logic holdn_s,
    output logic holding_o,
    output logic sck_rise_o,
    output logic sck_fall_o
);
    logic sck_prev;

    // Remember the previous clock level; it is tracked during a pause too.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_prev <= 1'b0;
        else        sck_prev <= sck_s;
    end

    // Pause begins with hold low, clock low and selected; it ends only with hold high.
    always_ff @(posedge clk) begin
        if (!rst_n)                          holding_o <= 1'b0;
        else if (holdn_s)                    holding_o <= 1'b0;
        else if (!csn_s && !sck_s)           holding_o <= 1'b1;
    end

    assign sck_rise_o =  sck_s & ~sck_prev & ~holding_o;
    assign sck_fall_o = ~sck_s &  sck_prev & ~holding_o;

    // R10: a pause can only begin from a low clock while selected.
    p_hold_start_clk_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(holding_o) |-> $past(!sck_s && !csn_s && !holdn_s));
endmodule

// File: rtl/spi_fe_ram.sv
// Synchronous byte RAM model of the storage array.
// Assumes: one write port driven by the commit logic, one read port with a
// registered output (one clock of latency).
module spi_fe_ram #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [7:0]        wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [7:0]        rdata_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem [DEPTH];

    // Write port.
    always_ff @(posedge clk) begin
        if (we_i) mem[waddr_i] <= wdata_i;
    end

    // Registered read port.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata_o <= 8'h00;
        else        rdata_o <= mem[raddr_i];
    end
endmodule

// File: rtl/spi_fe_ctrl.sv
// Command sequencer: bit counting, opcode decode, address capture, data-out
// shifting, and command pulses for the neighbouring status and page logic.
// Assumes: synchronized pins, pause-gated edges from spi_fe_pace, and a read
// port with one clock of latency.
// The RAM is read continuously at rd_addr_o.
module spi_fe_ctrl
    import spi_fe_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int PAGE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csn_s,
    input  logic              din_s,
    input  logic              holding,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              wip_i,
    input  logic [7:0]        status_i,
    input  logic [7:0]        ram_rdata,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              miso_o,
    output logic              miso_oe_o,
    output logic              wel_set_o,
    output logic              wel_clr_o,
    output logic [7:0]        sr_byte_o,
    output logic              sr_byte_valid_o,
    output logic              sr_commit_o,
    output logic [7:0]        pg_byte_o,
    output logic [ADDR_W-1:0] pg_addr_o,
    output logic              pg_byte_valid_o,
    output logic              pg_commit_o
);
    localparam int HI_W = ADDR_W - PAGE_W;

    fe_state_e         state;
    logic [2:0]        bit_cnt;
    logic [6:0]        in_sh;
    logic [ADDR_W-2:0] addr_sr;
    logic              addr_hi_done;
    logic              op_is_rd;
    logic [ADDR_W-1:0] wr_addr;
    logic              wr_any;
    logic [6:0]        out_sh;
    logic              out_live;

    logic [7:0]        new_byte;
    logic              byte_done;
    logic [ADDR_W-1:0] addr_full;
    logic              out_state;
    logic [7:0]        load_byte;

    // Byte being completed by the current rising edge, and derived flags.
    always_comb begin
        new_byte  = {in_sh, din_s};
        byte_done = (bit_cnt == 3'd7);
        addr_full = {addr_sr, din_s};
        out_state = (state == ST_RD) || (state == ST_SR_OUT);
        load_byte = (state == ST_RD) ? ram_rdata : status_i;
    end

    // Main sequencer: deselect clears, otherwise ungated edges advance the command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state           <= ST_WAIT;
            bit_cnt         <= '0;
            in_sh           <= '0;
            addr_sr         <= '0;
            addr_hi_done    <= 1'b0;
            op_is_rd        <= 1'b0;
            rd_addr_o       <= '0;
            wr_addr         <= '0;
            wr_any          <= 1'b0;
            out_sh          <= '0;
            out_live        <= 1'b0;
            miso_o          <= 1'b0;
            wel_set_o       <= 1'b0;
            wel_clr_o       <= 1'b0;
            sr_byte_o       <= '0;
            sr_byte_valid_o <= 1'b0;
            sr_commit_o     <= 1'b0;
            pg_byte_o       <= '0;
            pg_addr_o       <= '0;
            pg_byte_valid_o <= 1'b0;
            pg_commit_o     <= 1'b0;
        end else begin
            wel_set_o       <= 1'b0;
            wel_clr_o       <= 1'b0;
            sr_byte_valid_o <= 1'b0;
            sr_commit_o     <= 1'b0;
            pg_byte_valid_o <= 1'b0;
            pg_commit_o     <= 1'b0;
            if (csn_s) begin
                if (state == ST_SR_DONE)                         sr_commit_o <= 1'b1;
                if (state == ST_WR && wr_any && bit_cnt == 3'd0) pg_commit_o <= 1'b1;
                state        <= ST_IDLE;
                bit_cnt      <= '0;
                in_sh        <= '0;
                addr_hi_done <= 1'b0;
                wr_any       <= 1'b0;
                out_sh       <= '0;
                out_live     <= 1'b0;
            end else if (!holding) begin
                if (state == ST_IDLE) state <= ST_OPC;
                if (sck_rise && state != ST_WAIT) begin
                    bit_cnt <= bit_cnt + 3'd1;
                    in_sh   <= new_byte[6:0];
                    case (state)
                        ST_IDLE, ST_OPC: begin
                            if (byte_done) begin
                                case (new_byte)
                                    OP_WEN:  begin wel_set_o <= 1'b1; state <= ST_WAIT; end
                                    OP_WDIS: begin wel_clr_o <= 1'b1; state <= ST_WAIT; end
                                    OP_SRD:  state <= ST_SR_OUT;
                                    OP_SWR:  state <= ST_SR_IN;
                                    OP_MRD:  begin
                                        op_is_rd <= 1'b1;
                                        state    <= wip_i ? ST_WAIT : ST_ADDR;
                                    end
                                    OP_MWR:  begin op_is_rd <= 1'b0; state <= ST_ADDR; end
                                    default: state <= ST_WAIT;
                                endcase
                            end
                        end
                        ST_ADDR: begin
                            addr_sr <= addr_full[ADDR_W-2:0];
                            if (byte_done) begin
                                if (!addr_hi_done) begin
                                    addr_hi_done <= 1'b1;
                                end else if (op_is_rd) begin
                                    rd_addr_o <= addr_full;
                                    state     <= ST_RD;
                                end else begin
                                    wr_addr <= addr_full;
                                    state   <= ST_WR;
                                end
                            end
                        end
                        ST_WR: begin
                            if (byte_done) begin
                                pg_byte_valid_o <= 1'b1;
                                pg_byte_o       <= new_byte;
                                pg_addr_o       <= wr_addr;
                                wr_addr         <= {wr_addr[ADDR_W-1 -: HI_W],
                                                    wr_addr[PAGE_W-1:0] + 1'b1};
                                wr_any          <= 1'b1;
                            end
                        end
                        ST_SR_IN: begin
                            if (byte_done) begin
                                sr_byte_valid_o <= 1'b1;
                                sr_byte_o       <= new_byte;
                                state           <= ST_SR_DONE;
                            end
                        end
                        ST_SR_DONE: state <= ST_WAIT;
                        default: ;
                    endcase
                end
                if (sck_fall && out_state) begin
                    if (bit_cnt == 3'd0) begin
                        miso_o   <= load_byte[7];
                        out_sh   <= load_byte[6:0];
                        out_live <= 1'b1;
                        if (state == ST_RD) rd_addr_o <= rd_addr_o + 1'b1;
                    end else begin
                        miso_o <= out_sh[6];
                        out_sh <= {out_sh[5:0], 1'b0};
                    end
                end
            end
        end
    end

    assign miso_oe_o = out_live && out_state && !holding && !csn_s;

    // R1: one clock after chip select is seen high, data-out is released.
    p_desel_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        csn_s |=> !miso_oe_o);

    // R3, R9: the wait state is left only by deselect.
    p_wait_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && !csn_s) |=> (state == ST_WAIT));

    // R10: during a pause the bit position and the output bit do not move.
    p_hold_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (holding && !csn_s) |=> ($stable(bit_cnt) && $stable(miso_o)));

    // R2: data-out changes only in the clock after a falling edge.
    p_out_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !sck_fall |=> $stable(miso_o));

    // R6: a read command during a write cycle goes to the wait state.
    p_busy_reject_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_rise && !csn_s && !holding && (state == ST_OPC || state == ST_IDLE) &&
         byte_done && new_byte == OP_MRD && wip_i) |=> (state == ST_WAIT));

    // R8: at most one command event per clock.
    p_single_event_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wel_set_o, wel_clr_o, sr_byte_valid_o, sr_commit_o,
                  pg_byte_valid_o, pg_commit_o}));
endmodule

// File: rtl/spi_mem_front.sv
// Top of the serial memory front end: pin synchronizers, edge and pause
// tracking, command sequencer and the storage RAM model.
// Assumes: the system clock is several times faster than the serial clock,
// with at least four system clocks in each serial clock phase.
module spi_mem_front #(
    parameter int ADDR_W      = 10,
    parameter int PAGE_W      = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck_i,
    input  logic              spi_csn_i,
    input  logic              spi_mosi_i,
    input  logic              spi_holdn_i,
    output logic              spi_miso_o,
    output logic              spi_miso_oe_o,
    input  logic              wip_i,
    input  logic [7:0]        status_i,
    output logic              wel_set_o,
    output logic              wel_clr_o,
    output logic [7:0]        sr_byte_o,
    output logic              sr_byte_valid_o,
    output logic              sr_commit_o,
    output logic [7:0]        pg_byte_o,
    output logic [ADDR_W-1:0] pg_addr_o,
    output logic              pg_byte_valid_o,
    output logic              pg_commit_o,
    input  logic              mem_we_i,
    input  logic [ADDR_W-1:0] mem_waddr_i,
    input  logic [7:0]        mem_wdata_i
);
    localparam int PIN_N = 4;

    logic [PIN_N-1:0]  pins_s;
    logic              sck_s, csn_s, din_s, holdn_s;
    logic              holding, sck_rise, sck_fall;
    logic [ADDR_W-1:0] rd_addr;
    logic [7:0]        ram_rdata;

    spi_fe_sync #(.WIDTH(PIN_N), .STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({spi_holdn_i, spi_csn_i, spi_mosi_i, spi_sck_i}),
        .q_o   (pins_s)
    );

    assign {holdn_s, csn_s, din_s, sck_s} = pins_s;

    spi_fe_pace pace_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sck_s      (sck_s),
        .csn_s      (csn_s),
        .holdn_s    (holdn_s),
        .holding_o  (holding),
        .sck_rise_o (sck_rise),
        .sck_fall_o (sck_fall)
    );

    spi_fe_ctrl #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) ctrl_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .csn_s           (csn_s),
        .din_s           (din_s),
        .holding         (holding),
        .sck_rise        (sck_rise),
        .sck_fall        (sck_fall),
        .wip_i           (wip_i),
        .status_i        (status_i),
        .ram_rdata       (ram_rdata),
        .rd_addr_o       (rd_addr),
        .miso_o          (spi_miso_o),
        .miso_oe_o       (spi_miso_oe_o),
        .wel_set_o       (wel_set_o),
        .wel_clr_o       (wel_clr_o),
        .sr_byte_o       (sr_byte_o),
        .sr_byte_valid_o (sr_byte_valid_o),
        .sr_commit_o     (sr_commit_o),
        .pg_byte_o       (pg_byte_o),
        .pg_addr_o       (pg_addr_o),
        .pg_byte_valid_o (pg_byte_valid_o),
        .pg_commit_o     (pg_commit_o)
    );

    spi_fe_ram #(.ADDR_W(ADDR_W)) ram_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (mem_we_i),
        .waddr_i (mem_waddr_i),
        .wdata_i (mem_wdata_i),
        .raddr_i (rd_addr),
        .rdata_o (ram_rdata)
    );
endmodule

// File: tb/spi_mem_front_tb_top.sv
// Directed bench: one task per scenario, each checking its own results.
module spi_mem_front_tb_top;
    localparam int ADDR_W = 10;
    localparam int PAGE_W = 6;
    localparam int HALF   = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, csn = 1'b0, mosi = 1'b0, holdn = 1'b1;
    logic miso, miso_oe;
    logic wip = 1'b0;
    logic [7:0] status = 8'hA5;
    logic wel_set, wel_clr, sr_valid, sr_commit, pg_valid, pg_commit;
    logic [7:0] sr_byte, pg_byte;
    logic [ADDR_W-1:0] pg_addr;
    logic mem_we = 1'b0;
    logic [ADDR_W-1:0] mem_waddr = '0;
    logic [7:0] mem_wdata = '0;

    int n_chk = 0, n_err = 0;
    int c_set = 0, c_clr = 0, c_srv = 0, c_src = 0, c_pgv = 0, c_pgc = 0, c_oe = 0;
    logic [7:0] last_sr;
    logic [7:0] pg_b [16];
    logic [ADDR_W-1:0] pg_a [16];
    bit chk_stable = 0;
    bit done = 0;

    always #10 clk = ~clk;

    spi_mem_front #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .spi_sck_i(sck), .spi_csn_i(csn), .spi_mosi_i(mosi), .spi_holdn_i(holdn),
        .spi_miso_o(miso), .spi_miso_oe_o(miso_oe),
        .wip_i(wip), .status_i(status),
        .wel_set_o(wel_set), .wel_clr_o(wel_clr),
        .sr_byte_o(sr_byte), .sr_byte_valid_o(sr_valid), .sr_commit_o(sr_commit),
        .pg_byte_o(pg_byte), .pg_addr_o(pg_addr), .pg_byte_valid_o(pg_valid),
        .pg_commit_o(pg_commit),
        .mem_we_i(mem_we), .mem_waddr_i(mem_waddr), .mem_wdata_i(mem_wdata)
    );

    // Event monitors at the ports.
    always @(posedge clk) begin
        if (rst_n) begin
            if (wel_set)   c_set++;
            if (wel_clr)   c_clr++;
            if (sr_valid)  begin c_srv++; last_sr = sr_byte; end
            if (sr_commit) c_src++;
            if (pg_valid)  begin pg_b[c_pgv % 16] = pg_byte; pg_a[c_pgv % 16] = pg_addr; c_pgv++; end
            if (pg_commit) c_pgc++;
            if (miso_oe)   c_oe++;
        end
    end

    function automatic logic [7:0] fdat(input int a);
        return 8'((a * 37 + 11) & 255);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One serial bit; returns data-out sampled just before the rising edge.
    task automatic bit_io(input bit m3, input bit b, output bit r);
        if (m3) begin
            sck = 1'b0; mosi = b; wait_clk(HALF);
            r = miso; sck = 1'b1; wait_clk(HALF);
        end else begin
            mosi = b; wait_clk(HALF);
            r = miso; sck = 1'b1; wait_clk(HALF - 1);
            if (chk_stable && miso_oe) check("R2 stable across rise", miso, r);
            wait_clk(1); sck = 1'b0;
        end
    endtask

    task automatic byte_io(input bit m3, input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            bit r;
            bit_io(m3, tx[i], r);
            rx = {rx[6:0], r};
        end
    endtask

    task automatic sel(input bit m3);
        sck = m3; wait_clk(3); csn = 1'b0; wait_clk(HALF);
    endtask

    task automatic desel();
        wait_clk(HALF); csn = 1'b1; wait_clk(12);
    endtask

    task automatic t_reset();
        logic [7:0] rx;
        check("R1 oe after reset", miso_oe, 0);
        byte_io(0, 8'h06, rx);
        wait_clk(6);
        check("R1 no command without chip select edge", c_set, 0);
        desel();
        check("R1 oe while deselected", miso_oe, 0);
    endtask

    task automatic t_wren_wait();
        logic [7:0] rx;
        int s0 = c_set, k0 = c_clr;
        sel(0); byte_io(0, 8'h06, rx); byte_io(0, 8'h04, rx); desel();
        check("R3 set pulse", c_set - s0, 1);
        check("R3 bits after command ignored", c_clr - k0, 0);
    endtask

    task automatic t_wrdi_m3();
        logic [7:0] rx;
        int k0 = c_clr;
        sel(1); byte_io(1, 8'h04, rx); desel();
        check("R2 R3 clear pulse in mode 3", c_clr - k0, 1);
    endtask

    task automatic t_rdsr();
        logic [7:0] rx;
        sel(0); byte_io(0, 8'h05, rx);
        chk_stable = 1;
        for (int i = 0; i < 3; i++) begin
            byte_io(0, 8'h00, rx);
            check("R4 status repeat", rx, 8'hA5);
        end
        chk_stable = 0;
        check("R4 oe during status read", miso_oe, 1);
        desel();
        check("R1 oe released", miso_oe, 0);
    endtask

    task automatic t_read_m0();
        logic [7:0] rx;
        sel(0); byte_io(0, 8'h03, rx); byte_io(0, 8'h00, rx); byte_io(0, 8'h12, rx);
        for (int i = 0; i < 3; i++) begin
            byte_io(0, 8'h00, rx);
            check("R5 sequential read", rx, fdat(16'h12 + i));
        end
        desel();
    endtask

    task automatic t_read_wrap_m3();
        logic [7:0] rx;
        int a;
        sel(1); byte_io(1, 8'h03, rx); byte_io(1, 8'hFF, rx); byte_io(1, 8'hFE, rx);
        for (int i = 0; i < 4; i++) begin
            byte_io(1, 8'h00, rx);
            a = (16'h3FE + i) % (1 << ADDR_W);
            check("R5 R2 wrap and upper bits ignored", rx, fdat(a));
        end
        desel();
    endtask

    task automatic t_read_busy();
        logic [7:0] rx;
        int o0;
        wip = 1'b1;
        o0 = c_oe;
        sel(0); byte_io(0, 8'h03, rx); byte_io(0, 8'h00, rx); byte_io(0, 8'h20, rx);
        byte_io(0, 8'h00, rx);
        check("R6 rejected read never drives", c_oe - o0, 0);
        desel();
        wip = 1'b0;
        sel(0); byte_io(0, 8'h03, rx); byte_io(0, 8'h00, rx); byte_io(0, 8'h20, rx);
        byte_io(0, 8'h00, rx);
        check("R6 read accepted when idle", rx, fdat(16'h20));
        desel();
    endtask

    task automatic t_write_page();
        logic [7:0] rx;
        int v0 = c_pgv, c0 = c_pgc;
        logic [7:0] d [4] = '{8'h11, 8'h22, 8'h33, 8'h44};
        logic [ADDR_W-1:0] ea [4] = '{10'h13E, 10'h13F, 10'h100, 10'h101};
        sel(0); byte_io(0, 8'h02, rx); byte_io(0, 8'h01, rx); byte_io(0, 8'h3E, rx);
        for (int i = 0; i < 4; i++) byte_io(0, d[i], rx);
        desel();
        check("R7 byte count", c_pgv - v0, 4);
        for (int i = 0; i < 4; i++) begin
            check("R7 page byte", pg_b[(v0 + i) % 16], d[i]);
            check("R7 page wrap address", pg_a[(v0 + i) % 16], ea[i]);
        end
        check("R8 write commit", c_pgc - c0, 1);
    endtask

    task automatic t_write_partial();
        logic [7:0] rx;
        bit r;
        int v0 = c_pgv, c0 = c_pgc;
        sel(0); byte_io(0, 8'h02, rx); byte_io(0, 8'h00, rx); byte_io(0, 8'h05, rx);
        byte_io(0, 8'h5A, rx);
        for (int i = 0; i < 3; i++) bit_io(0, 1'b1, r);
        desel();
        check("R7 one byte passed", c_pgv - v0, 1);
        check("R8 no commit with extra bits", c_pgc - c0, 0);
    endtask

    task automatic t_wrsr();
        logic [7:0] rx;
        bit r;
        int v0 = c_srv, c0 = c_src;
        sel(0); byte_io(0, 8'h01, rx); byte_io(0, 8'h8C, rx); desel();
        check("R8 status byte value", last_sr, 8'h8C);
        check("R8 status commit", c_src - c0, 1);
        sel(0); byte_io(0, 8'h01, rx); byte_io(0, 8'h3C, rx); bit_io(0, 1'b0, r); desel();
        check("R8 status byte pulses", c_srv - v0, 2);
        check("R8 no status commit on 9 bits", c_src - c0, 1);
    endtask

    task automatic t_bad_opcode();
        logic [7:0] rx;
        int s0 = c_set, o0 = c_oe;
        sel(0); byte_io(0, 8'hAB, rx); byte_io(0, 8'h06, rx); byte_io(0, 8'h05, rx); desel();
        check("R9 unknown opcode ignores rest", c_set - s0, 0);
        check("R9 no output after unknown opcode", c_oe - o0, 0);
    endtask

    task automatic t_hold();
        logic [7:0] rx;
        bit r;
        sel(0); byte_io(0, 8'h03, rx); byte_io(0, 8'h00, rx); byte_io(0, 8'h40, rx);
        byte_io(0, 8'h00, rx);
        check("R10 first byte", rx, fdat(16'h40));
        rx = '0;
        for (int i = 0; i < 3; i++) begin bit_io(0, 1'b0, r); rx = {rx[6:0], r}; end
        holdn = 1'b0; wait_clk(6);
        check("R10 oe off during pause", miso_oe, 0);
        for (int i = 0; i < 3; i++) begin
            mosi = 1'b1; sck = 1'b1; wait_clk(HALF); sck = 1'b0; wait_clk(HALF);
        end
        check("R10 oe still off", miso_oe, 0);
        holdn = 1'b1; wait_clk(6);
        check("R10 oe back after pause", miso_oe, 1);
        for (int i = 0; i < 5; i++) begin bit_io(0, 1'b0, r); rx = {rx[6:0], r}; end
        check("R10 byte continues after pause", rx, fdat(16'h41));
        desel();
    endtask

    task automatic t_hold_desel();
        logic [7:0] rx;
        bit r;
        int s0 = c_set;
        sel(0);
        for (int i = 0; i < 4; i++) bit_io(0, 1'b0, r);
        holdn = 1'b0; wait_clk(6);
        csn = 1'b1; wait_clk(12);
        csn = 1'b0; wait_clk(HALF);
        byte_io(0, 8'h06, rx);
        desel();
        check("R11 paused reselect ignored", c_set - s0, 0);
        holdn = 1'b1; wait_clk(6);
        sel(0); byte_io(0, 8'h06, rx); desel();
        check("R11 accepted after hold high and reselect", c_set - s0, 1);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        wait_clk(4);
        rst_n = 1'b1;
        for (int a = 0; a < (1 << ADDR_W); a++) begin
            mem_we = 1'b1; mem_waddr = ADDR_W'(a); mem_wdata = fdat(a);
            wait_clk(1);
        end
        mem_we = 1'b0;
        wait_clk(4);
        t_reset();
        t_wren_wait();
        t_wrdi_m3();
        t_rdsr();
        t_read_m0();
        t_read_wrap_m3();
        t_read_busy();
        t_write_page();
        t_write_partial();
        t_wrsr();
        t_bad_opcode();
        t_hold();
        t_hold_desel();
        done = 1;
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=running expected=finished");
            finish_run();
        end
    end
endmodule